// File: doc/BRIEF.md
# Indirect Branch Path History Buffer

This block keeps an ordered record of the indirect branches that a front end has predicted. Each record holds the branch address, its target and a sequence number. The records are stored in a circular array with a fixed number of slots, so that an index hash for a target cache can be built from the recent path. A prediction appends a record at the young end. Commits, which are keyed by sequence number, move a committed boundary forward from the old end. The buffer keeps at most `PATH_LEN` committed records and releases the oldest one once that limit is reached.

A squash, also keyed by sequence number, removes the first record that is younger than the given number and every record after it. When a branch resolves, a fix-up port overwrites the target of the youngest record. The buffer exports two views of the targets, both newest first. The first view covers the whole buffer. The second view skips the youngest record, so that the hash used for that record's own update excludes the record itself. Sequence numbers wrap around, and all age comparisons are made modulo 2^`SEQ_W`.

Top module: `path_hist_buf`

## Requirements
- R1: After reset the buffer is empty. `count_o`, `committed_o`, `overflow_o`, `path_vld_o` and `prior_vld_o` are zero, and every lane and the oldest-record outputs read zero.
- R2: When `push_i` is set on a buffer that is not full, the record (`push_pc_i`, `push_tgt_i`, `push_seq_i`) is added as the youngest entry and `count_o` increases by one on the next cycle.
- R3: When `push_i` is set on a full buffer (`count_o` equal to `DEPTH`), the oldest record is dropped and the new record is appended. `count_o` stays at `DEPTH`, `overflow_o` is high for exactly the following cycle, and `committed_o` decreases by one if it was nonzero.
- R4: A commit with value S advances `committed_o` by one when the first uncommitted record exists, its sequence number is at or before S, and `committed_o` is below `PATH_LEN`. If that record's sequence number is after S, the commit has no effect.
- R5: When a commit meets the R4 conditions while `committed_o` is already `PATH_LEN` or more, the oldest record is dropped instead. `count_o` decreases by one and `committed_o` is unchanged.
- R6: A commit on an empty buffer, or on a buffer whose records are all committed, changes no output.
- R7: A squash with value S truncates the buffer just before the first record, counted from the oldest, whose sequence number is strictly after S. `committed_o` is then clamped to the new `count_o`.
- R8: "a is after b" means that the `SEQ_W`-bit difference a-b, read as a signed number, is greater than zero. Ordering therefore holds across the wrap of the sequence counter.
- R9: When `fix_i` is set, the target of the youngest record is replaced by `fix_tgt_i`. On an empty buffer this has no effect.
- R10: Lane k of `path_tgt_o` (bits [k*TGT_W +: TGT_W]) holds the target of the k-th newest record, with k=0 the youngest. `path_vld_o[k]` is set when more than k records exist. Lanes that are not valid read zero.
- R11: Lane k of `prior_tgt_o` holds the target of the (k+1)-th newest record, which skips the youngest. `prior_vld_o[k]` is set when more than k+1 records exist, and lanes that are not valid read zero.
- R12: When several operations arrive in one cycle, they take effect in this order: squash, then commit, then fix-up of the youngest surviving record, then append.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Append a record |
| push_pc_i | input | PC_W | Branch address of the new record |
| push_tgt_i | input | TGT_W | Predicted target of the new record |
| push_seq_i | input | SEQ_W | Sequence number of the new record |
| commit_i | input | 1 | Commit request |
| commit_seq_i | input | SEQ_W | Sequence number being committed |
| squash_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Records after this number are removed |
| fix_i | input | 1 | Overwrite the youngest target |
| fix_tgt_i | input | TGT_W | Resolved target |
| count_o | output | CNT_W | Number of records held |
| committed_o | output | CNT_W | Number of committed records held |
| overflow_o | output | 1 | Previous append dropped a record |
| oldest_pc_o | output | PC_W | Branch address of the oldest record (zero if empty) |
| oldest_seq_o | output | SEQ_W | Sequence number of the oldest record (zero if empty) |
| path_tgt_o | output | PATH_LEN*TGT_W | Newest-first targets |
| path_vld_o | output | PATH_LEN | Lane valid bits for path_tgt_o |
| prior_tgt_o | output | PATH_LEN*TGT_W | Newest-first targets excluding the youngest |
| prior_vld_o | output | PATH_LEN | Lane valid bits for prior_tgt_o |

## Verification
The bench targets these corner cases:

- **Committed-record limit.** A commit that reaches the limit must release the oldest record. A design that keeps counting up would report a committed count above `PATH_LEN` and keep a count that is too high.
- **Stale commit.** A commit older than the next uncommitted record must do nothing. A design that skips this comparison would advance early.
- **Squash position.** The squash is placed across the sequence wrap (250 to 1). A comparison done without modular arithmetic would remove records that should stay, or keep records that should go.
- **Full buffer.** An append into a full buffer must flag the overflow and pull the committed boundary back. If it does not, later commits land on the wrong record.
- **Same-cycle operations.** Cycles combine squash, commit, fix-up and append, and a random phase mixes them further. This exposes a wrong operation order as a lane, count or oldest-record mismatch.

// File: rtl/phb_pkg.sv
package phb_pkg;

  typedef enum logic [1:0] {
    CM_NONE = 2'd0,
    CM_ADV  = 2'd1,
    CM_POP  = 2'd2
  } commit_act_e;

endpackage

// File: rtl/phb_squash_scan.sv
// Finds the first age-ordered slot younger than the squash point.
module phb_squash_scan #(
  parameter  int unsigned DEPTH = 16,
  parameter  int unsigned SEQ_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [SEQ_W-1:0] seq_i [DEPTH],
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SEQ_W-1:0] ref_i,
  output logic [CNT_W-1:0] keep_o
);

  logic [DEPTH-1:0] young;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [SEQ_W-1:0] diff;
    assign diff     = seq_i[i] - ref_i;
    assign young[i] = (CNT_W'(i) < cnt_i) && !diff[SEQ_W-1] && (diff != '0);
  end

  always_comb begin
    keep_o = cnt_i;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (young[i]) keep_o = CNT_W'(i);
    end
  end

endmodule

// File: rtl/phb_commit_ctl.sv
module phb_commit_ctl
  import phb_pkg::*;
#(
  parameter int unsigned SEQ_W    = 8,
  parameter int unsigned PATH_LEN = 4,
  parameter int unsigned CNT_W    = 5
) (
  input  logic             commit_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] head_i,
  input  logic [SEQ_W-1:0] head_seq_i,
  input  logic [SEQ_W-1:0] ref_i,
  output commit_act_e      act_o
);

  logic [SEQ_W-1:0] diff;
  logic             at_or_before;

  assign diff         = head_seq_i - ref_i;
  assign at_or_before = diff[SEQ_W-1] || (diff == '0);

  always_comb begin
    act_o = CM_NONE;
    if (commit_i && (head_i < cnt_i) && at_or_before) begin
      act_o = (head_i >= CNT_W'(PATH_LEN)) ? CM_POP : CM_ADV;
    end
  end

endmodule

// File: rtl/phb_path_tap.sv
// Newest-first target view; SKIP drops that many youngest records.
module phb_path_tap #(
  parameter  int unsigned DEPTH    = 16,
  parameter  int unsigned PATH_LEN = 4,
  parameter  int unsigned TGT_W    = 32,
  parameter  int unsigned SKIP     = 0,
  localparam int unsigned PTR_W    = $clog2(DEPTH),
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic [TGT_W-1:0]          tgt_i [DEPTH],
  input  logic [PTR_W-1:0]          rd_i,
  input  logic [CNT_W-1:0]          cnt_i,
  output logic [PATH_LEN*TGT_W-1:0] lane_o,
  output logic [PATH_LEN-1:0]       vld_o
);

  for (genvar k = 0; k < PATH_LEN; k++) begin : g_lane
    localparam int unsigned BACK = k + SKIP + 1;
    logic [PTR_W-1:0] idx;
    assign vld_o[k] = (cnt_i >= CNT_W'(BACK));
    assign idx      = rd_i + PTR_W'(cnt_i - CNT_W'(BACK));
    assign lane_o[k*TGT_W +: TGT_W] = vld_o[k] ? tgt_i[idx] : '0;
  end

endmodule

// File: rtl/path_hist_buf.sv
module path_hist_buf
  import phb_pkg::*;
#(
  parameter  int unsigned DEPTH    = 16,  // power of two, >= 2
  parameter  int unsigned PATH_LEN = 4,   // < DEPTH
  parameter  int unsigned PC_W     = 32,
  parameter  int unsigned TGT_W    = 32,
  parameter  int unsigned SEQ_W    = 8,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      push_i,
  input  logic [PC_W-1:0]           push_pc_i,
  input  logic [TGT_W-1:0]          push_tgt_i,
  input  logic [SEQ_W-1:0]          push_seq_i,
  input  logic                      commit_i,
  input  logic [SEQ_W-1:0]          commit_seq_i,
  input  logic                      squash_i,
  input  logic [SEQ_W-1:0]          squash_seq_i,
  input  logic                      fix_i,
  input  logic [TGT_W-1:0]          fix_tgt_i,
  output logic [CNT_W-1:0]          count_o,
  output logic [CNT_W-1:0]          committed_o,
  output logic                      overflow_o,
  output logic [PC_W-1:0]           oldest_pc_o,
  output logic [SEQ_W-1:0]          oldest_seq_o,
  output logic [PATH_LEN*TGT_W-1:0] path_tgt_o,
  output logic [PATH_LEN-1:0]       path_vld_o,
  output logic [PATH_LEN*TGT_W-1:0] prior_tgt_o,
  output logic [PATH_LEN-1:0]       prior_vld_o
);

  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [PC_W-1:0]  pc_q  [DEPTH];
  logic [TGT_W-1:0] tgt_q [DEPTH];
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [SEQ_W-1:0] ord_seq [DEPTH];

  logic [PTR_W-1:0] rd_q, rd_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] head_q, head_n;
  logic             ovf_q, ovf_n;

  logic [CNT_W-1:0] keep_cnt, cnt1, head1, cnt2, head2;
  logic [PTR_W-1:0] rd2, wr_idx, fix_idx;
  logic [SEQ_W-1:0] head_seq;
  logic             fix_en, full;
  commit_act_e      act;

  // Age-ordered view of sequence numbers, oldest at slot 0.
  for (genvar i = 0; i < DEPTH; i++) begin : g_ord
    assign ord_seq[i] = seq_q[rd_q + PTR_W'(i)];
  end

  phb_squash_scan #(
    .DEPTH (DEPTH),
    .SEQ_W (SEQ_W)
  ) u_scan (
    .seq_i  (ord_seq),
    .cnt_i  (cnt_q),
    .ref_i  (squash_seq_i),
    .keep_o (keep_cnt)
  );

  // Stage 1: squash.
  always_comb begin
    cnt1  = squash_i ? keep_cnt : cnt_q;
    head1 = (head_q > cnt1) ? cnt1 : head_q;
  end

  assign head_seq = ord_seq[head1[PTR_W-1:0]];

  // Stage 2: commit.
  phb_commit_ctl #(
    .SEQ_W    (SEQ_W),
    .PATH_LEN (PATH_LEN),
    .CNT_W    (CNT_W)
  ) u_commit (
    .commit_i   (commit_i),
    .cnt_i      (cnt1),
    .head_i     (head1),
    .head_seq_i (head_seq),
    .ref_i      (commit_seq_i),
    .act_o      (act)
  );

  always_comb begin
    rd2   = rd_q;
    cnt2  = cnt1;
    head2 = head1;
    unique case (act)
      CM_POP: begin
        rd2  = rd_q + PTR_W'(1);
        cnt2 = cnt1 - CNT_W'(1);
      end
      CM_ADV:  head2 = head1 + CNT_W'(1);
      default: ;
    endcase
  end

  // Stage 3: fix-up of youngest survivor (a pop never moves the tail).
  assign fix_en  = fix_i && (cnt1 != '0);
  assign fix_idx = rd_q + PTR_W'(cnt1 - CNT_W'(1));

  // Stage 4: append.
  assign full   = push_i && (cnt2 == CNT_W'(DEPTH));
  assign wr_idx = rd2 + PTR_W'(cnt2);

  always_comb begin
    rd_n   = rd2;
    cnt_n  = cnt2;
    head_n = head2;
    ovf_n  = 1'b0;
    if (push_i) begin
      if (full) begin
        rd_n  = rd2 + PTR_W'(1);
        ovf_n = 1'b1;
        if (head2 != '0) head_n = head2 - CNT_W'(1);
      end else begin
        cnt_n = cnt2 + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      cnt_q  <= '0;
      head_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      rd_q   <= rd_n;
      cnt_q  <= cnt_n;
      head_q <= head_n;
      ovf_q  <= ovf_n;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fix_en) tgt_q[fix_idx] <= fix_tgt_i;
    if (push_i) begin
      pc_q[wr_idx]  <= push_pc_i;
      tgt_q[wr_idx] <= push_tgt_i;
      seq_q[wr_idx] <= push_seq_i;
    end
  end

  phb_path_tap #(
    .DEPTH    (DEPTH),
    .PATH_LEN (PATH_LEN),
    .TGT_W    (TGT_W),
    .SKIP     (0)
  ) u_tap_all (
    .tgt_i  (tgt_q),
    .rd_i   (rd_q),
    .cnt_i  (cnt_q),
    .lane_o (path_tgt_o),
    .vld_o  (path_vld_o)
  );

  phb_path_tap #(
    .DEPTH    (DEPTH),
    .PATH_LEN (PATH_LEN),
    .TGT_W    (TGT_W),
    .SKIP     (1)
  ) u_tap_prior (
    .tgt_i  (tgt_q),
    .rd_i   (rd_q),
    .cnt_i  (cnt_q),
    .lane_o (prior_tgt_o),
    .vld_o  (prior_vld_o)
  );

  assign count_o      = cnt_q;
  assign committed_o  = head_q;
  assign overflow_o   = ovf_q;
  assign oldest_pc_o  = (cnt_q != '0) ? pc_q[rd_q]  : '0;
  assign oldest_seq_o = (cnt_q != '0) ? seq_q[rd_q] : '0;

endmodule

// File: rtl/path_hist_buf_chk.sv
module path_hist_buf_chk #(
  parameter  int unsigned DEPTH = 16,
  parameter  int unsigned TGT_W = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic             commit_i,
  input logic             squash_i,
  input logic             fix_i,
  input logic [TGT_W-1:0] fix_tgt_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] committed_o,
  input logic             overflow_o,
  input logic [TGT_W-1:0] newest_tgt_i,
  input logic             newest_vld_i
);

  // R1 / R7: occupancy bounds
  a_r1_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (committed_o <= count_o) && (count_o <= CNT_W'(DEPTH)));

  a_r2_append_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !squash_i && !commit_i && (count_o < CNT_W'(DEPTH))
    |=> count_o == $past(count_o) + CNT_W'(1));

  a_r3_overflow_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> $past(push_i) && ($past(count_o) == CNT_W'(DEPTH)));

  a_r3_full_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !squash_i && !commit_i && (count_o == CNT_W'(DEPTH))
    |=> (count_o == CNT_W'(DEPTH)) && overflow_o);

  a_r6_empty_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !push_i && !squash_i && (count_o == '0)
    |=> (count_o == '0) && (committed_o == '0));

  a_r7_squash_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i && !push_i |=> count_o <= $past(count_o));

  a_r9_fix_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_i && !push_i && !squash_i && !commit_i && (count_o != '0)
    |=> newest_tgt_i == $past(fix_tgt_i));

  a_r10_lane0_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    newest_vld_i == (count_o != '0));

endmodule

bind path_hist_buf path_hist_buf_chk #(
  .DEPTH (DEPTH),
  .TGT_W (TGT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_i       (push_i),
  .commit_i     (commit_i),
  .squash_i     (squash_i),
  .fix_i        (fix_i),
  .fix_tgt_i    (fix_tgt_i),
  .count_o      (count_o),
  .committed_o  (committed_o),
  .overflow_o   (overflow_o),
  .newest_tgt_i (path_tgt_o[TGT_W-1:0]),
  .newest_vld_i (path_vld_o[0])
);

// File: tb/path_hist_buf_tb.sv
module path_hist_buf_tb;

  localparam int DEPTH = 8;
  localparam int PL    = 3;
  localparam int PW    = 16;
  localparam int TW    = 16;
  localparam int SW    = 8;
  localparam int CW    = 4;

  typedef struct {
    logic [PW-1:0] pc;
    logic [TW-1:0] tgt;
    logic [SW-1:0] seq;
  } ent_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          push_i = 0, commit_i = 0, squash_i = 0, fix_i = 0;
  logic [PW-1:0] push_pc_i = '0;
  logic [TW-1:0] push_tgt_i = '0, fix_tgt_i = '0;
  logic [SW-1:0] push_seq_i = '0, commit_seq_i = '0, squash_seq_i = '0;
  logic [CW-1:0] count_o, committed_o;
  logic          overflow_o;
  logic [PW-1:0] oldest_pc_o;
  logic [SW-1:0] oldest_seq_o;
  logic [PL*TW-1:0] path_tgt_o, prior_tgt_o;
  logic [PL-1:0]    path_vld_o, prior_vld_o;

  path_hist_buf #(
    .DEPTH(DEPTH), .PATH_LEN(PL), .PC_W(PW), .TGT_W(TW), .SEQ_W(SW)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .push_i(push_i), .push_pc_i(push_pc_i), .push_tgt_i(push_tgt_i), .push_seq_i(push_seq_i),
    .commit_i(commit_i), .commit_seq_i(commit_seq_i),
    .squash_i(squash_i), .squash_seq_i(squash_seq_i),
    .fix_i(fix_i), .fix_tgt_i(fix_tgt_i),
    .count_o(count_o), .committed_o(committed_o), .overflow_o(overflow_o),
    .oldest_pc_o(oldest_pc_o), .oldest_seq_o(oldest_seq_o),
    .path_tgt_o(path_tgt_o), .path_vld_o(path_vld_o),
    .prior_tgt_o(prior_tgt_o), .prior_vld_o(prior_vld_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference model
  ent_t mq[$];
  int   mhead = 0;

  // scoreboard queues
  string            tag_q[$];
  int               exp_cnt_q[$], exp_head_q[$];
  bit               exp_ovf_q[$];
  logic [PL*TW-1:0] exp_lane_q[$], exp_pri_q[$];
  logic [PL-1:0]    exp_vld_q[$], exp_pvld_q[$];
  logic [PW-1:0]    exp_opc_q[$];
  logic [SW-1:0]    exp_oseq_q[$];

  function automatic bit after(logic [SW-1:0] a, logic [SW-1:0] b);
    logic [SW-1:0] d;
    d = a - b;
    return !d[SW-1] && (d != '0);
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag,
                     input bit p, input logic [PW-1:0] ppc, input logic [TW-1:0] ptgt,
                     input logic [SW-1:0] ps,
                     input bit c, input logic [SW-1:0] cs,
                     input bit q, input logic [SW-1:0] qs,
                     input bit f, input logic [TW-1:0] ft);
    ent_t e;
    bit ovf;
    logic [PL*TW-1:0] lane, pri;
    logic [PL-1:0] vld, pvld;
    int cut;
    @(negedge clk);
    push_i = p; push_pc_i = ppc; push_tgt_i = ptgt; push_seq_i = ps;
    commit_i = c; commit_seq_i = cs;
    squash_i = q; squash_seq_i = qs;
    fix_i = f; fix_tgt_i = ft;
    // R12 order: squash, commit, fix, append
    if (q) begin
      cut = mq.size();
      for (int i = 0; i < mq.size(); i++) begin
        if (after(mq[i].seq, qs)) begin cut = i; break; end
      end
      while (mq.size() > cut) void'(mq.pop_back());
      if (mhead > mq.size()) mhead = mq.size();
    end
    if (c && mhead < mq.size() && !after(mq[mhead].seq, cs)) begin
      if (mhead >= PL) void'(mq.pop_front());
      else mhead++;
    end
    if (f && mq.size() > 0) begin
      e = mq[mq.size()-1];
      e.tgt = ft;
      mq[mq.size()-1] = e;
    end
    ovf = 0;
    if (p) begin
      if (mq.size() == DEPTH) begin
        void'(mq.pop_front());
        ovf = 1;
        if (mhead > 0) mhead--;
      end
      e.pc = ppc; e.tgt = ptgt; e.seq = ps;
      mq.push_back(e);
    end
    lane = '0; pri = '0; vld = '0; pvld = '0;
    for (int k = 0; k < PL; k++) begin
      if (mq.size() > k) begin
        vld[k] = 1'b1;
        lane[k*TW +: TW] = mq[mq.size()-1-k].tgt;
      end
      if (mq.size() > k + 1) begin
        pvld[k] = 1'b1;
        pri[k*TW +: TW] = mq[mq.size()-2-k].tgt;
      end
    end
    tag_q.push_back(tag);
    exp_cnt_q.push_back(mq.size());
    exp_head_q.push_back(mhead);
    exp_ovf_q.push_back(ovf);
    exp_lane_q.push_back(lane);
    exp_pri_q.push_back(pri);
    exp_vld_q.push_back(vld);
    exp_pvld_q.push_back(pvld);
    exp_opc_q.push_back(mq.size() > 0 ? mq[0].pc : '0);
    exp_oseq_q.push_back(mq.size() > 0 ? mq[0].seq : '0);
    @(posedge clk);
    #1;
    push_i = 0; commit_i = 0; squash_i = 0; fix_i = 0;
  endtask

  task automatic push(string tag, logic [PW-1:0] pc, logic [TW-1:0] t, logic [SW-1:0] s);
    cyc(tag, 1, pc, t, s, 0, '0, 0, '0, 0, '0);
  endtask
  task automatic commit(string tag, logic [SW-1:0] s);
    cyc(tag, 0, '0, '0, '0, 1, s, 0, '0, 0, '0);
  endtask
  task automatic squash(string tag, logic [SW-1:0] s);
    cyc(tag, 0, '0, '0, '0, 0, '0, 1, s, 0, '0);
  endtask
  task automatic fix(string tag, logic [TW-1:0] t);
    cyc(tag, 0, '0, '0, '0, 0, '0, 0, '0, 1, t);
  endtask

  // monitor: compares outputs one cycle after each driven step
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (tag_q.size() > 0) begin
        string t;
        t = tag_q.pop_front();
        chk(t, "count", 64'(count_o), 64'(exp_cnt_q.pop_front()));
        chk(t, "committed", 64'(committed_o), 64'(exp_head_q.pop_front()));
        chk(t, "overflow", 64'(overflow_o), 64'(exp_ovf_q.pop_front()));
        chk(t, "path_tgt", 64'(path_tgt_o), 64'(exp_lane_q.pop_front()));
        chk(t, "path_vld", 64'(path_vld_o), 64'(exp_vld_q.pop_front()));
        chk(t, "prior_tgt (R11)", 64'(prior_tgt_o), 64'(exp_pri_q.pop_front()));
        chk(t, "prior_vld (R11)", 64'(prior_vld_o), 64'(exp_pvld_q.pop_front()));
        chk(t, "oldest_pc", 64'(oldest_pc_o), 64'(exp_opc_q.pop_front()));
        chk(t, "oldest_seq", 64'(oldest_seq_o), 64'(exp_oseq_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] nseq;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "count", 64'(count_o), 0);
    chk("R1", "committed", 64'(committed_o), 0);
    chk("R1", "overflow", 64'(overflow_o), 0);
    chk("R1", "path_vld", 64'(path_vld_o), 0);
    chk("R1", "prior_vld", 64'(prior_vld_o), 0);
    chk("R1", "path_tgt", 64'(path_tgt_o), 0);
    chk("R1", "oldest_pc", 64'(oldest_pc_o), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 5; i++)
      push("R2", PW'(16'h1000 + i * 4), TW'(16'h2000 + i * 16), SW'(10 + i));
    fix("R9", 16'hBEEF);
    push("R10", 16'h1100, 16'h2100, 8'd15);
    commit("R4", 8'd10);
    commit("R4", 8'd11);
    commit("R4", 8'd9);        // stale: no effect
    commit("R4", 8'd12);       // reaches PATH_LEN
    commit("R5", 8'd13);       // pops oldest
    commit("R5", 8'd14);
    commit("R6", 8'd20);
    commit("R6", 8'd30);       // all committed: no effect
    squash("R7", 8'd13);
    squash("R7", 8'd5);        // removes everything
    commit("R6", 8'd50);       // empty
    fix("R9", 16'h1234);       // empty: no effect

    for (int i = 0; i < 8; i++)
      push("R3", PW'(16'h3000 + i), TW'(16'h4000 + i), SW'(40 + i));
    commit("R3", 8'd40);
    push("R3", 16'h3008, 16'h4008, 8'd48);
    push("R3", 16'h3009, 16'h4009, 8'd49);

    squash("R8", 8'd20);
    for (int i = 0; i < 8; i++)
      push("R8", PW'(16'h5000 + i), TW'(16'h6000 + i), SW'(250 + i));
    squash("R8", 8'd254);
    commit("R8", 8'd252);
    commit("R8", 8'd1);
    cyc("R12", 1, 16'h7000, 16'h8000, 8'd2, 1, 8'd253, 1, 8'd253, 1, 16'hCAFE);
    for (int i = 0; i < 4; i++)
      push("R12", PW'(16'h7100 + i), TW'(16'h8100 + i), SW'(3 + i));
    cyc("R12", 1, 16'h7200, 16'h8200, 8'd7, 1, 8'd255, 0, '0, 1, 16'hF00D);

    nseq = 8'd8;
    for (int n = 0; n < 400; n++) begin
      bit p, c, q, f;
      logic [SW-1:0] cs, qs;
      p  = ($urandom % 3) != 0;
      c  = ($urandom % 3) == 0;
      q  = ($urandom % 7) == 0;
      f  = ($urandom % 4) == 0;
      cs = (mq.size() > 0) ? mq[0].seq + SW'($urandom % 4) : nseq;
      qs = nseq - SW'(1 + $urandom % 5);
      cyc("R12", p, PW'($urandom), TW'($urandom), nseq, c, cs, q, qs, f, TW'($urandom));
      if (p) nseq = nseq + 1'b1;
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule